// File: doc/BRIEF.md
# PHY Management Register Model

This block gives a host a two-word window onto the management registers of a gigabit Ethernet PHY, and holds a behavioural model of that register set. The host writes a command word. It carries a PHY register address, a device address and two strobe bits, one for read and one for write. A second word holds the value to be written, and it is where the value that was read comes back. Each command takes effect on the clock edge that writes the command word. Nothing models serial pin timing, so the strobe bits never read back as busy.

The model holds the basic control, basic status and advertisement registers, plus an interrupt-enable register and a pending-interrupt register that clears when read. Link-up and link-down event pulses from the port side update the status bits and set pending interrupt flags. A single interrupt output is high while any flag is pending. The identifier registers and a few capability registers return constants. Every other register address reads zero and discards writes.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the command and data words are zero and the interrupt output is low. Basic control (address 0) reads 0x1140, basic status (address 1) reads 0x796D, advertisement (address 4) reads 0x0DE1, and interrupt enable (address 18) and interrupt pending (address 19) read 0.
- R2: The host selects the command word with `wr_sel_i`=0, and the model keeps it. The register address is in bits 25:21 and the device address in bits 20:16. Bit 26 requests a read and bit 27 requests a write; when both are set the write is done and no read takes place. The stored command reads back with bits 27:26 cleared and every other bit kept. A command with neither strobe bit only stores the word. The device address does not select anything.
- R3: A read command places the 16-bit register value in data word bits 31:16 and clears bits 15:0 in the same clock edge.
- R4: A host write to the data word (`wr_sel_i`=1) keeps bits 15:0 and zeroes bits 31:16. A write command takes its value from data word bits 15:0.
- R5: A write to basic control with bit 15 clear stores the value ANDed with 0x79C0. The kept bits are 14, 13, 12, 11, 8, 7 and 6.
- R6: A write to basic control with bit 15 set restores basic control, basic status, advertisement, interrupt enable and interrupt pending to their R1 values, and drops the interrupt output.
- R7: A write to basic control with bit 12 set, and bit 15 clear, sets basic status bit 5 (autonegotiation complete).
- R8: A write to advertisement stores (value AND 0x2D7F) OR 0x0080.
- R9: Interrupt enable keeps only bits 7:0 on write. A read of interrupt pending returns the pending bits and clears them in the same edge. An event arriving in that same cycle is still recorded.
- R10: A link-down pulse clears status bits 2 and 5 and sets pending bit 8. A link-up pulse sets status bits 2 and 5 and sets pending bit 11. If both pulses arrive together, link-down wins. `phy_irq_o` is high while any pending bit is set.
- R11: Address 2 returns parameter ID_HI and address 3 returns parameter ID_LO. Address 5 returns 0x45E1, address 6 returns 0x0001, address 9 returns 0x0300 and address 10 returns 0x0800. Every other unlisted address reads 0 and discards writes.
- R12: Basic status (address 1) cannot be written from the host; a write to it leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | 0 selects the command word, 1 selects the data word |
| wr_data_i | input | 32 | Host write value |
| cmd_o | output | 32 | Command word as currently held |
| data_o | output | 32 | Data word as currently held |
| link_down_i | input | 1 | Link-down event pulse |
| link_up_i | input | 1 | Link-up event pulse |
| phy_irq_o | output | 1 | High while any PHY interrupt is pending |

## Verification
The hardest case to reach from the ports is a link event that lands in the same clock edge as a read of the pending register. The read must return the old flags and clear them, and the new flag must survive. The bench drives a link pulse in the same cycle as the command-word write that requests the read. It checks the returned value, then reads the pending register again to find the new flag. A second case applies both link pulses in one cycle to show that link-down takes priority, in both the status bits and the pending flags.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int HOST_W      = 32;
  localparam int REG_DW      = 16;
  localparam int REG_AW      = 5;
  localparam int INT_EN_W    = 8;

  // command word layout
  localparam int CMD_RD_BIT  = 26;
  localparam int CMD_WR_BIT  = 27;
  localparam int CMD_REG_LSB = 21;
  localparam int RDATA_LSB   = 16;

  // register addresses
  localparam logic [REG_AW-1:0] A_CTRL    = 5'd0;
  localparam logic [REG_AW-1:0] A_STAT    = 5'd1;
  localparam logic [REG_AW-1:0] A_ID_HI   = 5'd2;
  localparam logic [REG_AW-1:0] A_ID_LO   = 5'd3;
  localparam logic [REG_AW-1:0] A_ADV     = 5'd4;
  localparam logic [REG_AW-1:0] A_PARTNER = 5'd5;
  localparam logic [REG_AW-1:0] A_EXPN    = 5'd6;
  localparam logic [REG_AW-1:0] A_GB_CTRL = 5'd9;
  localparam logic [REG_AW-1:0] A_GB_STAT = 5'd10;
  localparam logic [REG_AW-1:0] A_INT_EN  = 5'd18;
  localparam logic [REG_AW-1:0] A_INT_ST  = 5'd19;

  // reset values and masks
  localparam logic [REG_DW-1:0] CTRL_RST_VAL = 16'h1140;
  localparam logic [REG_DW-1:0] STAT_RST_VAL = 16'h796D;
  localparam logic [REG_DW-1:0] ADV_RST_VAL  = 16'h0DE1;
  localparam logic [REG_DW-1:0] CTRL_WMASK   = 16'h79C0;
  localparam logic [REG_DW-1:0] ADV_WMASK    = 16'h2D7F;
  localparam logic [REG_DW-1:0] ADV_FORCE    = 16'h0080;

  // fixed read values
  localparam logic [REG_DW-1:0] PARTNER_VAL  = 16'h45E1;
  localparam logic [REG_DW-1:0] EXPN_VAL     = 16'h0001;
  localparam logic [REG_DW-1:0] GB_CTRL_VAL  = 16'h0300;
  localparam logic [REG_DW-1:0] GB_STAT_VAL  = 16'h0800;

  // bit positions
  localparam int CTRL_SOFT_RST = 15;
  localparam int CTRL_AN_EN    = 12;
  localparam int STAT_LINK     = 2;
  localparam int STAT_AN_DONE  = 5;
  localparam int INT_LINK_DN   = 8;
  localparam int INT_AN_DONE   = 11;
endpackage

// File: rtl/phy_host_if.sv
module phy_host_if
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [HOST_W-1:0] wr_data_i,
  input  logic [REG_DW-1:0] rdata_i,
  output logic [HOST_W-1:0] cmd_o,
  output logic [HOST_W-1:0] data_o,
  output logic              phy_wr_o,
  output logic              phy_rd_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [REG_DW-1:0] wdata_o
);
  localparam int LOW_W = HOST_W - REG_DW;

  logic [HOST_W-1:0] cmd_q, data_q;
  logic              cmd_hit, data_hit;

  assign cmd_hit    = wr_en_i & ~wr_sel_i;
  assign data_hit   = wr_en_i &  wr_sel_i;
  assign phy_wr_o   = cmd_hit &  wr_data_i[CMD_WR_BIT];
  assign phy_rd_o   = cmd_hit &  wr_data_i[CMD_RD_BIT] & ~wr_data_i[CMD_WR_BIT];
  assign reg_addr_o = wr_data_i[CMD_REG_LSB +: REG_AW];
  assign wdata_o    = data_q[REG_DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_hit) begin
        cmd_q <= wr_data_i;
        cmd_q[CMD_WR_BIT] <= 1'b0;   // ops finish in this edge
        cmd_q[CMD_RD_BIT] <= 1'b0;
      end
      if (data_hit)
        data_q <= {{LOW_W{1'b0}}, wr_data_i[REG_DW-1:0]};
      else if (phy_rd_o)
        data_q <= {rdata_i, {LOW_W{1'b0}}};
    end
  end

  assign cmd_o  = cmd_q;
  assign data_o = data_q;

  p_strobe_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit |=> (cmd_o[CMD_WR_BIT:CMD_RD_BIT] == 2'b00) &&
                (cmd_o[CMD_RD_BIT-1:0] == $past(wr_data_i[CMD_RD_BIT-1:0])));

  p_rd_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rd_o |=> (data_o[LOW_W-1:0] == '0) && (data_o[HOST_W-1:RDATA_LSB] == $past(rdata_i)));

  p_data_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_hit |=> (data_o[HOST_W-1:REG_DW] == '0));
endmodule

// File: rtl/phy_int_ctrl.sv
module phy_int_ctrl
  import phy_mgmt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                mask_we_i,
  input  logic [INT_EN_W-1:0] mask_d_i,
  input  logic                st_rd_i,
  input  logic                link_down_i,
  input  logic                link_up_i,
  output logic [REG_DW-1:0]   pend_o,
  output logic [INT_EN_W-1:0] mask_o,
  output logic                irq_o
);
  logic [REG_DW-1:0]   pend_q, set_vec, kept;
  logic [INT_EN_W-1:0] mask_q;

  always_comb begin
    set_vec = '0;
    if (link_down_i)    set_vec[INT_LINK_DN] = 1'b1;
    else if (link_up_i) set_vec[INT_AN_DONE] = 1'b1;
    kept = (soft_rst_i || st_rd_i) ? '0 : pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= kept | set_vec;   // new events survive a clearing read
      if (soft_rst_i)     mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |pend_q;

  p_rd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd_i && !link_down_i && !link_up_i) |=> (pend_o == '0) && !irq_o);

  p_dn_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_down_i |=> pend_o[INT_LINK_DN] && !pend_o[INT_AN_DONE] == !$past(pend_q[INT_AN_DONE] && !st_rd_i && !soft_rst_i) && irq_o);

  p_up_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_up_i && !link_down_i) |=> pend_o[INT_AN_DONE] && irq_o);

  p_rst_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !link_down_i && !link_up_i) |=> (pend_o == '0) && (mask_o == '0));
endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
  import phy_mgmt_pkg::*;
#(
  parameter logic [REG_DW-1:0] ID_HI = 16'h001C,
  parameter logic [REG_DW-1:0] ID_LO = 16'hC915
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [REG_DW-1:0]   wdata_i,
  input  logic                link_down_i,
  input  logic                link_up_i,
  input  logic [REG_DW-1:0]   pend_i,
  input  logic [INT_EN_W-1:0] mask_i,
  output logic [REG_DW-1:0]   rdata_o,
  output logic                soft_rst_o,
  output logic                mask_we_o,
  output logic                st_rd_o
);
  logic [REG_DW-1:0] ctrl_q, stat_q, adv_q, stat_d;
  logic              ctrl_we, adv_we;

  assign ctrl_we    = wr_i && (addr_i == A_CTRL);
  assign adv_we     = wr_i && (addr_i == A_ADV);
  assign soft_rst_o = ctrl_we && wdata_i[CTRL_SOFT_RST];
  assign mask_we_o  = wr_i && (addr_i == A_INT_EN);
  assign st_rd_o    = rd_i && (addr_i == A_INT_ST);

  always_comb begin
    stat_d = soft_rst_o ? STAT_RST_VAL : stat_q;
    if (ctrl_we && !soft_rst_o && wdata_i[CTRL_AN_EN])
      stat_d[STAT_AN_DONE] = 1'b1;   // autoneg completes at once
    if (link_down_i) begin
      stat_d[STAT_LINK]    = 1'b0;
      stat_d[STAT_AN_DONE] = 1'b0;
    end else if (link_up_i) begin
      stat_d[STAT_LINK]    = 1'b1;
      stat_d[STAT_AN_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST_VAL;
      stat_q <= STAT_RST_VAL;
      adv_q  <= ADV_RST_VAL;
    end else begin
      stat_q <= stat_d;
      if (soft_rst_o) begin
        ctrl_q <= CTRL_RST_VAL;
        adv_q  <= ADV_RST_VAL;
      end else begin
        if (ctrl_we) ctrl_q <= wdata_i & CTRL_WMASK;
        if (adv_we)  adv_q  <= (wdata_i & ADV_WMASK) | ADV_FORCE;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:    rdata_o = ctrl_q;
      A_STAT:    rdata_o = stat_q;
      A_ID_HI:   rdata_o = ID_HI;
      A_ID_LO:   rdata_o = ID_LO;
      A_ADV:     rdata_o = adv_q;
      A_PARTNER: rdata_o = PARTNER_VAL;
      A_EXPN:    rdata_o = EXPN_VAL;
      A_GB_CTRL: rdata_o = GB_CTRL_VAL;
      A_GB_STAT: rdata_o = GB_STAT_VAL;
      A_INT_EN:  rdata_o = {{(REG_DW-INT_EN_W){1'b0}}, mask_i};
      A_INT_ST:  rdata_o = pend_i;
      default:   rdata_o = '0;
    endcase
  end

  p_an_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && wdata_i[CTRL_AN_EN] && !link_down_i) |=> stat_q[STAT_AN_DONE]);

  p_link_dn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_down_i |=> !stat_q[STAT_LINK] && !stat_q[STAT_AN_DONE]);

  p_adv_tx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_we |=> adv_q[7] && ((adv_q & ~(ADV_WMASK | ADV_FORCE)) == '0));

  p_ctrl_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !wdata_i[CTRL_SOFT_RST]) |=> (ctrl_q == ($past(wdata_i) & CTRL_WMASK)));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] ID_HI = 16'h001C,
  parameter logic [15:0] ID_LO = 16'hC915
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] cmd_o,
  output logic [31:0] data_o,
  input  logic        link_down_i,
  input  logic        link_up_i,
  output logic        phy_irq_o
);
  logic                phy_wr, phy_rd, soft_rst, mask_we, st_rd;
  logic [REG_AW-1:0]   reg_addr;
  logic [REG_DW-1:0]   wdata, rdata, pend;
  logic [INT_EN_W-1:0] mask;

  phy_host_if u_host (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .rdata_i(rdata), .cmd_o, .data_o,
    .phy_wr_o(phy_wr), .phy_rd_o(phy_rd),
    .reg_addr_o(reg_addr), .wdata_o(wdata)
  );

  phy_reg_file #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(phy_wr), .rd_i(phy_rd), .addr_i(reg_addr), .wdata_i(wdata),
    .link_down_i, .link_up_i,
    .pend_i(pend), .mask_i(mask),
    .rdata_o(rdata), .soft_rst_o(soft_rst), .mask_we_o(mask_we), .st_rd_o(st_rd)
  );

  phy_int_ctrl u_int (
    .clk_i, .rst_ni,
    .soft_rst_i(soft_rst), .mask_we_i(mask_we), .mask_d_i(wdata[INT_EN_W-1:0]),
    .st_rd_i(st_rd), .link_down_i, .link_up_i,
    .pend_o(pend), .mask_o(mask), .irq_o(phy_irq_o)
  );
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
  localparam logic [15:0] TB_ID_HI = 16'h001C;
  localparam logic [15:0] TB_ID_LO = 16'hC915;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        link_dn = 1'b0;
  logic        link_up = 1'b0;
  logic [31:0] cmd, data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  phy_mgmt_regs #(.ID_HI(TB_ID_HI), .ID_LO(TB_ID_LO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cmd_o(cmd), .data_o(data),
    .link_down_i(link_dn), .link_up_i(link_up), .phy_irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // one host write with optional link pulses in the same cycle
  task automatic host_wr_ev(logic sel, logic [31:0] v, logic dn, logic up);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v; link_dn = dn; link_up = up;
    @(negedge clk);
    wr_en = 1'b0; link_dn = 1'b0; link_up = 1'b0;
  endtask

  task automatic host_wr(logic sel, logic [31:0] v);
    host_wr_ev(sel, v, 1'b0, 1'b0);
  endtask

  task automatic link_pulse(logic dn, logic up);
    @(negedge clk);
    link_dn = dn; link_up = up;
    @(negedge clk);
    link_dn = 1'b0; link_up = 1'b0;
  endtask

  function automatic logic [31:0] rd_cmd(logic [4:0] a, logic [4:0] dev);
    return (32'h1 << 26) | (32'(a) << 21) | (32'(dev) << 16);
  endfunction

  task automatic phy_wr(logic [4:0] a, logic [15:0] v);
    host_wr(1'b1, {16'h0, v});
    host_wr(1'b0, (32'h1 << 27) | (32'(a) << 21));
  endtask

  task automatic phy_rd(logic [4:0] a, output logic [15:0] v);
    host_wr(1'b0, rd_cmd(a, 5'd0));
    v = data[31:16];
  endtask

  task automatic expect_reg(string req, logic [4:0] a, logic [15:0] exp);
    logic [15:0] v;
    phy_rd(a, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic t_reset;
    check("R1 cmd", cmd, 32'h0);
    check("R1 data", data, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    expect_reg("R1 ctrl", 5'd0, 16'h1140);
    expect_reg("R1 stat", 5'd1, 16'h796D);
    expect_reg("R1 adv", 5'd4, 16'h0DE1);
    expect_reg("R1 int_en", 5'd18, 16'h0000);
    expect_reg("R1 int_st", 5'd19, 16'h0000);
  endtask

  task automatic t_decode;
    logic [31:0] c;
    host_wr(1'b1, 32'hDEAD_BEEF);
    check("R4 data low only", data, 32'h0000_BEEF);
    host_wr(1'b0, 32'h002A_1234);
    check("R2 no strobe stored", cmd, 32'h002A_1234);
    check("R2 no strobe data kept", data, 32'h0000_BEEF);
    c = rd_cmd(5'd2, 5'd31) | 32'h55;
    host_wr(1'b0, c);
    check("R2 strobe cleared", cmd, c & ~(32'h3 << 26));
    check("R3 read upper half", data, {TB_ID_HI, 16'h0});
    host_wr(1'b1, 32'h0);
    host_wr(1'b0, (32'h3 << 26) | (32'd4 << 21));
    check("R2 both strobes no read", data, 32'h0);
    expect_reg("R2 both strobes wrote", 5'd4, 16'h0080);
  endtask

  task automatic t_adv_ctrl;
    phy_wr(5'd4, 16'hFFFF);
    expect_reg("R8 adv mask", 5'd4, 16'h2DFF);
    phy_wr(5'd0, 16'h7FFF);
    expect_reg("R5 ctrl mask", 5'd0, 16'h79C0);
    phy_wr(5'd0, 16'h0000);
    expect_reg("R5 ctrl zero", 5'd0, 16'h0000);
  endtask

  task automatic t_link_int;
    link_pulse(1'b1, 1'b0);
    check("R10 irq after down", {31'h0, irq}, 32'h1);
    expect_reg("R10 stat down", 5'd1, 16'h7949);
    expect_reg("R9 pending down", 5'd19, 16'h0100);
    check("R9 irq cleared by read", {31'h0, irq}, 32'h0);
    expect_reg("R9 pending cleared", 5'd19, 16'h0000);
    phy_wr(5'd0, 16'h0000);
    expect_reg("R7 no autoneg", 5'd1, 16'h7949);
    phy_wr(5'd0, 16'h1000);
    expect_reg("R7 autoneg done", 5'd1, 16'h7969);
    link_pulse(1'b0, 1'b1);
    expect_reg("R10 stat up", 5'd1, 16'h796D);
    expect_reg("R10 pending up", 5'd19, 16'h0800);
    phy_wr(5'd18, 16'hABCD);
    expect_reg("R9 enable 8 bits", 5'd18, 16'h00CD);
  endtask

  task automatic t_same_cycle;
    link_pulse(1'b1, 1'b0);
    host_wr_ev(1'b0, rd_cmd(5'd19, 5'd0), 1'b0, 1'b1);
    check("R9 read returns old", {16'h0, data[31:16]}, 32'h0100);
    check("R9 irq from new event", {31'h0, irq}, 32'h1);
    expect_reg("R9 new event kept", 5'd19, 16'h0800);
    link_pulse(1'b1, 1'b1);
    expect_reg("R10 both stat", 5'd1, 16'h7949);
    expect_reg("R10 both pending", 5'd19, 16'h0100);
  endtask

  task automatic t_soft_reset;
    link_pulse(1'b0, 1'b1);
    link_pulse(1'b1, 1'b0);
    phy_wr(5'd0, 16'h8000);
    check("R6 irq dropped", {31'h0, irq}, 32'h0);
    expect_reg("R6 ctrl", 5'd0, 16'h1140);
    expect_reg("R6 stat", 5'd1, 16'h796D);
    expect_reg("R6 adv", 5'd4, 16'h0DE1);
    expect_reg("R6 int_en", 5'd18, 16'h0000);
    expect_reg("R6 int_st", 5'd19, 16'h0000);
  endtask

  task automatic t_fixed;
    expect_reg("R11 id hi", 5'd2, TB_ID_HI);
    expect_reg("R11 id lo", 5'd3, TB_ID_LO);
    expect_reg("R11 partner", 5'd5, 16'h45E1);
    expect_reg("R11 expansion", 5'd6, 16'h0001);
    expect_reg("R11 gb ctrl", 5'd9, 16'h0300);
    expect_reg("R11 gb stat", 5'd10, 16'h0800);
    expect_reg("R11 addr 7", 5'd7, 16'h0000);
    phy_wr(5'd31, 16'hFFFF);
    expect_reg("R11 addr 31 ignores write", 5'd31, 16'h0000);
    phy_wr(5'd16, 16'h1234);
    expect_reg("R11 addr 16 ignores write", 5'd16, 16'h0000);
    phy_wr(5'd1, 16'h0000);
    expect_reg("R12 status read only", 5'd1, 16'h796D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_adv_ctrl();
    t_link_int();
    t_same_cycle();
    t_soft_reset();
    t_fixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule